// File: doc/BRIEF.md
# Vertical Sync Mode Recognition Controller

This controller sits beside a field line counter in a digital vertical timing chain. Its job is to decide, once per field, how the counter is restarted. In standard mode the counter runs a locked count and is restarted at its own terminal value, so the incoming integrated vertical sync is used only as a reference. In non-standard mode the counter is restarted by the incoming sync pulse, so that the internal timing follows the source from one field to the next. When no sync arrives, the counter restarts at a longer free-run limit so that capture is quick once sync comes back.

All inputs are sampled only in cycles where the twice-line-rate enable is high. Each time a counter restart is requested, the field is closed and judged. It counts as coincident if a sync pulse arrived within one count of the terminal value. To qualify for standard mode, the controller needs a run of coincident fields plus enough equalizing strobes in a short window before the terminal count. A second path into standard mode opens when the sync input shows repeated pulses during the active-scan window. Once locked, the mode survives a limited run of bad fields. A force input holds the controller in non-standard mode.

Top module: `vsync_mode_top`

## Requirements
- R1: In non-standard mode, stdMode goes high in the cycle after a field closes when that field is the seventh consecutive coincident field (or later) and it carried at least 9 equalizing strobes. Strobes count only when fieldCount is in 533..544.
- R2: A closing field with seven or more coincident fields but fewer than 9 equalizing strobes leaves stdMode low. The coincidence count saturates at 7, so the next coincident field with 9 strobes enters standard mode.
- R3: A field is coincident when a sync pulse is sampled with fieldCount in 544..546 (terminal 545, plus or minus one). A pulse at 543 does not qualify.
- R4: In standard mode, stdMode stays high through six consecutive non-coincident fields. A coincident field clears the miss count.
- R5: The seventh consecutive non-coincident field in standard mode drops stdMode in the following cycle. The coincidence run then restarts from zero.
- R6: If two or more sync pulses are sampled with fieldCount in 100..483, and the field closes coincident while in non-standard mode, stdMode rises in the next cycle. Neither the seven-field run nor the strobe count is required. The noise count clears when the window opens and when a field closes.
- R7: In standard mode, counterReset is high exactly in enabled cycles with fieldCount equal to 545. The sync input does not affect it.
- R8: In non-standard mode, counterReset is high in enabled cycles that either carry a sync pulse outside 100..483 or have fieldCount equal to 704. Sync pulses inside 100..483 do not restart the field.
- R9: While forceAsync is high, stdMode is low from the next cycle on. The coincidence, miss and per-field strobe counts are cleared.
- R10: In cycles with tick2fh low, counterReset is low and ivSync and eqStrobe have no effect.
- R11: After reset, stdMode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick2fh | input | 1 | Twice-line-rate enable; qualifies all other inputs |
| fieldCount | input | 10 | Current value of the external field line counter |
| ivSync | input | 1 | Integrated vertical sync pulse, sampled on enabled cycles |
| eqStrobe | input | 1 | Equalizing-pulse strobe, sampled on enabled cycles |
| forceAsync | input | 1 | High holds non-standard mode |
| stdMode | output | 1 | High in standard (locked) mode |
| counterReset | output | 1 | Request to reload the field counter; also closes the field |

## Verification
The assertions rely on two assumptions. First, fieldCount behaves like a real counter: it reloads after counterReset and advances by one on each enabled cycle. Second, ivSync and eqStrobe mean something only on enabled cycles. The bench keeps to the first assumption by building fieldCount itself from its own expected restart decisions. It places sync, strobe and noise pulses at chosen counter values within each field. On disabled cycles it drives random junk on ivSync and eqStrobe. The force input changes only at field starts, and the enable is dropped at random.

// File: rtl/vsync_mode_pkg.sv
package vsync_mode_pkg;

  // strobes from the mode control to the field datapath
  typedef struct packed {
    logic fieldEnd;   // field is being closed this cycle
    logic forceClr;   // forced non-standard: drop per-field accumulators
  } modeStrobe_t;

  // decoded per-cycle status from the datapath
  typedef struct packed {
    logic syncTick;    // sync pulse on an enabled cycle
    logic inNoiseWin;  // counter inside active-scan window
    logic atTerm;      // counter at locked terminal value
    logic atFree;      // counter at free-run limit
    logic fieldHit;    // field is coincident (including this cycle)
    logic eqOk;        // enough equalizing strobes (including this cycle)
    logic noisy;       // noise threshold reached in this field
  } fieldStatus_t;

endpackage

// File: rtl/vsync_field_dp.sv
module vsync_field_dp
  import vsync_mode_pkg::*;
#(
  parameter int COUNT_W     = 10,
  parameter int TERM        = 545,
  parameter int FREE_TERM   = 704,
  parameter int COIN_WIN    = 1,
  parameter int EQ_START    = 533,
  parameter int EQ_SPAN     = 12,
  parameter int EQ_MIN      = 9,
  parameter int NOISE_START = 100,
  parameter int NOISE_SPAN  = 384,
  parameter int NOISE_MIN   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick2fh,
  input  logic [COUNT_W-1:0] fieldCount,
  input  logic               ivSync,
  input  logic               eqStrobe,
  input  modeStrobe_t        strb,
  output fieldStatus_t       st
);

  localparam logic [COUNT_W-1:0] COIN_LO  = COUNT_W'(TERM - COIN_WIN);
  localparam logic [COUNT_W-1:0] COIN_HI  = COUNT_W'(TERM + COIN_WIN);
  localparam logic [COUNT_W-1:0] EQ_LO    = COUNT_W'(EQ_START);
  localparam logic [COUNT_W-1:0] EQ_HI    = COUNT_W'(EQ_START + EQ_SPAN - 1);
  localparam logic [COUNT_W-1:0] NOISE_LO = COUNT_W'(NOISE_START);
  localparam logic [COUNT_W-1:0] NOISE_HI = COUNT_W'(NOISE_START + NOISE_SPAN - 1);
  localparam logic [COUNT_W-1:0] TERM_V   = COUNT_W'(TERM);
  localparam logic [COUNT_W-1:0] FREE_V   = COUNT_W'(FREE_TERM);
  localparam int EQ_W    = $clog2(EQ_MIN + 1);
  localparam int NOISE_W = $clog2(NOISE_MIN + 1);

  logic               syncTick, inCoinWin, inEqWin, inNoiseWin, noiseOpen;
  logic               coinNow, eqNow;
  logic               hitSeen;
  logic [EQ_W-1:0]    eqCount;
  logic [EQ_W:0]      eqSum;
  logic [NOISE_W-1:0] noiseCount;

  // window decode
  always_comb begin
    syncTick   = tick2fh & ivSync;
    inCoinWin  = (fieldCount >= COIN_LO)  && (fieldCount <= COIN_HI);
    inEqWin    = (fieldCount >= EQ_LO)    && (fieldCount <= EQ_HI);
    inNoiseWin = (fieldCount >= NOISE_LO) && (fieldCount <= NOISE_HI);
    noiseOpen  = tick2fh && (fieldCount == NOISE_LO);
    coinNow    = syncTick & inCoinWin;
    eqNow      = tick2fh & eqStrobe & inEqWin;
    eqSum      = {1'b0, eqCount} + {{EQ_W{1'b0}}, eqNow};
  end

  // coincidence flag for the running field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              hitSeen <= 1'b0;
    else if (strb.fieldEnd | strb.forceClr) hitSeen <= 1'b0;
    else if (coinNow)                       hitSeen <= 1'b1;
  end

  // equalizing strobe counter, saturating at threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              eqCount <= '0;
    else if (strb.fieldEnd | strb.forceClr) eqCount <= '0;
    else if (eqNow && eqCount != EQ_W'(EQ_MIN)) eqCount <= eqCount + 1'b1;
  end

  // noise pulse counter for the active-scan window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              noiseCount <= '0;
    else if (strb.fieldEnd) noiseCount <= '0;
    else if (noiseOpen)     noiseCount <= syncTick ? NOISE_W'(1) : '0;
    else if (syncTick && inNoiseWin && noiseCount != NOISE_W'(NOISE_MIN))
      noiseCount <= noiseCount + 1'b1;
  end

  always_comb begin
    st.syncTick   = syncTick;
    st.inNoiseWin = inNoiseWin;
    st.atTerm     = tick2fh && (fieldCount == TERM_V);
    st.atFree     = tick2fh && (fieldCount == FREE_V);
    st.fieldHit   = hitSeen | coinNow;
    st.eqOk       = eqSum >= (EQ_W + 1)'(EQ_MIN);
    st.noisy      = noiseCount >= NOISE_W'(NOISE_MIN);
  end

  // R2
  eq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.fieldEnd) |-> (eqCount == '0));

  // R6
  noise_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (noiseOpen && !syncTick && !strb.fieldEnd) |=> (noiseCount == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick2fh && !strb.fieldEnd && !strb.forceClr) |=> $stable(eqCount) && $stable(hitSeen));

endmodule

// File: rtl/vsync_mode_ctrl.sv
module vsync_mode_ctrl
  import vsync_mode_pkg::*;
#(
  parameter int COIN_NEED  = 7,
  parameter int MISS_LIMIT = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick2fh,
  input  logic         forceAsync,
  input  fieldStatus_t st,
  output modeStrobe_t  strb,
  output logic         stdMode,
  output logic         counterReset
);

  localparam int COIN_W = $clog2(COIN_NEED + 1);
  localparam int MISS_W = $clog2(MISS_LIMIT);

  typedef enum logic {MODE_FREE = 1'b0, MODE_LOCK = 1'b1} mode_e;

  mode_e             modeReg, modeNext;
  logic [COIN_W-1:0] coinCnt, coinNext, coinInc;
  logic [MISS_W-1:0] missCnt, missNext;
  logic              fieldEnd;

  // restart request: own terminal when locked, sync or free-run limit otherwise
  always_comb begin
    if (modeReg == MODE_LOCK) fieldEnd = st.atTerm;
    else fieldEnd = (st.syncTick & ~st.inNoiseWin) | st.atFree;
    fieldEnd      = fieldEnd & tick2fh;
    strb.fieldEnd = fieldEnd;
    strb.forceClr = forceAsync;
  end

  always_comb begin
    modeNext = modeReg;
    coinNext = coinCnt;
    missNext = missCnt;
    coinInc  = (coinCnt == COIN_W'(COIN_NEED)) ? coinCnt : coinCnt + 1'b1;
    if (forceAsync) begin
      modeNext = MODE_FREE;
      coinNext = '0;
      missNext = '0;
    end else if (fieldEnd) begin
      if (modeReg == MODE_LOCK) begin
        if (st.fieldHit) missNext = '0;
        else if (missCnt == MISS_W'(MISS_LIMIT - 1)) begin
          modeNext = MODE_FREE;
          missNext = '0;
          coinNext = '0;
        end else missNext = missCnt + 1'b1;
      end else begin
        if (!st.fieldHit) coinNext = '0;
        else if ((coinInc == COIN_W'(COIN_NEED) && st.eqOk) || st.noisy) begin
          modeNext = MODE_LOCK;
          coinNext = '0;
          missNext = '0;
        end else coinNext = coinInc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_FREE;
      coinCnt <= '0;
      missCnt <= '0;
    end else begin
      modeReg <= modeNext;
      coinCnt <= coinNext;
      missCnt <= missNext;
    end
  end

  assign stdMode      = (modeReg == MODE_LOCK);
  assign counterReset = fieldEnd;

  // R9
  force_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceAsync |=> !stdMode);

  // R7
  lock_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stdMode && counterReset) |-> st.atTerm);

  // R10
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick2fh |-> !counterReset);

  // R1
  enter_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stdMode) |-> ($past(fieldEnd) && $past(st.fieldHit) && !$past(forceAsync)));

  // R5
  leave_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stdMode) |-> ($past(forceAsync) || ($past(fieldEnd) && !$past(st.fieldHit))));

endmodule

// File: rtl/vsync_mode_top.sv
module vsync_mode_top
  import vsync_mode_pkg::*;
#(
  parameter int COUNT_W     = 10,
  parameter int TERM        = 545,
  parameter int FREE_TERM   = 704,
  parameter int COIN_WIN    = 1,
  parameter int EQ_START    = 533,
  parameter int EQ_SPAN     = 12,
  parameter int EQ_MIN      = 9,
  parameter int NOISE_START = 100,
  parameter int NOISE_SPAN  = 384,
  parameter int NOISE_MIN   = 2,
  parameter int COIN_NEED   = 7,
  parameter int MISS_LIMIT  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick2fh,
  input  logic [COUNT_W-1:0] fieldCount,
  input  logic               ivSync,
  input  logic               eqStrobe,
  input  logic               forceAsync,
  output logic               stdMode,
  output logic               counterReset
);

  modeStrobe_t  strb;
  fieldStatus_t st;

  vsync_field_dp #(
    .COUNT_W(COUNT_W), .TERM(TERM), .FREE_TERM(FREE_TERM), .COIN_WIN(COIN_WIN),
    .EQ_START(EQ_START), .EQ_SPAN(EQ_SPAN), .EQ_MIN(EQ_MIN),
    .NOISE_START(NOISE_START), .NOISE_SPAN(NOISE_SPAN), .NOISE_MIN(NOISE_MIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick2fh(tick2fh), .fieldCount(fieldCount),
    .ivSync(ivSync), .eqStrobe(eqStrobe), .strb(strb), .st(st)
  );

  vsync_mode_ctrl #(
    .COIN_NEED(COIN_NEED), .MISS_LIMIT(MISS_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick2fh(tick2fh), .forceAsync(forceAsync),
    .st(st), .strb(strb), .stdMode(stdMode), .counterReset(counterReset)
  );

endmodule

// File: tb/tb_vsync_mode_top.sv
module tb_vsync_mode_top;

  localparam int TERM = 545, FREE_TERM = 704, PRESET = 20;
  localparam int WATCH_CYCLES = 190000;
  localparam int LAST_FIELD = 120;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick2fh = 1'b0;
  logic [9:0] fieldCount = 10'(PRESET);
  logic       ivSync = 1'b0, eqStrobe = 1'b0, forceAsync = 1'b0;
  logic       stdMode, counterReset;

  int checks = 0, errors = 0;
  bit done = 0;

  vsync_mode_top dut (
    .clk(clk), .rstN(rstN), .tick2fh(tick2fh), .fieldCount(fieldCount),
    .ivSync(ivSync), .eqStrobe(eqStrobe), .forceAsync(forceAsync),
    .stdMode(stdMode), .counterReset(counterReset)
  );

  always #2.5 clk = ~clk;

  // model state
  int fc = PRESET, fcNext = PRESET;
  bit mStd = 0, mHit = 0;
  int mCoin = 0, mMiss = 0, mEq = 0, mNoise = 0;
  // field plan
  int syncPos, eqNum, noiseNum, fieldIdx;
  bit planForce;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d field=%0d t=%0t", tag, act, exp, fieldIdx, $time);
    end
  endtask

  function automatic bit inNoise(int c); return c >= 100 && c <= 483; endfunction
  function automatic bit inCoin(int c);  return c >= TERM - 1 && c <= TERM + 1; endfunction
  function automatic bit inEqW(int c);   return c >= 533 && c <= 544; endfunction
  function automatic bit expReset(bit std, bit tk, bit sy, int c);
    if (!tk) return 0;
    if (std) return c == TERM;
    return (sy && !inNoise(c)) || c == FREE_TERM;
  endfunction
  function automatic int noiseAt(int k);
    return 150 + 100 * k;
  endfunction

  task automatic plan(int s, int e, int n, bit f);
    syncPos = s; eqNum = e; noiseNum = n; planForce = f;
  endtask

  task automatic pickPlan(int idx);
    int r;
    if (idx < 2)        plan(TERM, 12, 0, 1);
    else if (idx < 8)   plan(TERM, 12, 0, 0);
    else if (idx == 8)  plan(TERM, 8, 0, 0);
    else if (idx == 9)  plan(TERM - 1, 9, 0, 0);
    else if (idx < 16)  plan(-1, 12, 0, 0);
    else if (idx == 16) plan(TERM, 0, 0, 0);
    else if (idx < 24)  plan(-1, 12, 0, 0);
    else if (idx == 24) plan(TERM, 0, 2, 0);
    else if (idx < 32)  plan(-1, 0, 0, 0);
    else if (idx == 32) plan(TERM + 1, 0, 3, 0);
    else if (idx < 40)  plan(-1, 0, 0, 0);
    else if (idx == 40) plan(TERM - 2, 12, 2, 0);
    else begin
      r = $urandom % 10;
      case (r)
        0, 1, 2, 3: syncPos = TERM;
        4: syncPos = TERM - 1;
        5: syncPos = TERM + 1;
        6: syncPos = TERM - 2;
        7: syncPos = 60;
        8: syncPos = 300;
        default: syncPos = -1;
      endcase
      eqNum = ($urandom % 3 == 0) ? int'($urandom % 9) : 9 + int'($urandom % 4);
      noiseNum = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      planForce = ($urandom % 16 == 0);
    end
  endtask

  // directed expectations at the start of chosen fields
  task automatic fieldStartChecks(int idx);
    case (idx)
      2:  chk(stdMode == 0, "R9 forced fields", stdMode, 0);
      9:  chk(stdMode == 0, "R2 too few strobes", stdMode, 0);
      10: chk(stdMode == 1, "R1 lock after seven", stdMode, 1);
      16: chk(stdMode == 1, "R4 six misses kept", stdMode, 1);
      23: chk(stdMode == 1, "R4 miss count cleared", stdMode, 1);
      24: chk(stdMode == 0, "R5 seventh miss", stdMode, 0);
      25: chk(stdMode == 1, "R6 noise bypass", stdMode, 1);
      32: chk(stdMode == 0, "R5 drop again", stdMode, 0);
      33: chk(stdMode == 1, "R3 window plus one", stdMode, 1);
      41: chk(stdMode == 0, "R3 outside window", stdMode, 0);
      default: ;
    endcase
  endtask

  initial begin : main
    bit newField, tk, iv, eq, sy, eR, hitNow, eqOk, noisy, nStd;
    int eqNow, nCoin, nMiss;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(stdMode == 0, "R11 reset state", stdMode, 0);
    rstN = 1'b1;
    fieldIdx = 0;
    newField = 1;
    while (fieldIdx <= LAST_FIELD) begin
      @(negedge clk);
      fc = fcNext;
      if (newField) begin
        pickPlan(fieldIdx);
        fieldStartChecks(fieldIdx);
        newField = 0;
      end
      tk = ($urandom % 8) != 0;
      if (tk) begin
        iv = (fc == syncPos);
        for (int k = 0; k < noiseNum; k++) if (fc == noiseAt(k)) iv = 1;
        eq = (fc >= 533) && (fc < 533 + eqNum);
      end else begin
        iv = $urandom % 2;
        eq = $urandom % 2;
      end
      tick2fh = tk; ivSync = iv; eqStrobe = eq; forceAsync = planForce;
      fieldCount = 10'(fc);
      #1;
      sy = tk & iv;
      eR = expReset(mStd, tk, sy, fc);
      chk(counterReset == eR, tk ? (mStd ? "R7 restart" : "R8 restart") : "R10 idle restart",
          counterReset, eR);
      chk(stdMode == mStd, "R1 R2 R4 R5 R6 R9 mode", stdMode, mStd);
      // next-state model
      hitNow = mHit | (sy & inCoin(fc));
      eqNow  = mEq + ((tk && eq && inEqW(fc)) ? 1 : 0);
      eqOk   = eqNow >= 9;
      noisy  = mNoise >= 2;
      nStd = mStd; nCoin = mCoin; nMiss = mMiss;
      if (planForce) begin
        nStd = 0; nCoin = 0; nMiss = 0;
      end else if (eR) begin
        if (mStd) begin
          if (hitNow) nMiss = 0;
          else if (mMiss == 6) begin nStd = 0; nMiss = 0; nCoin = 0; end
          else nMiss = mMiss + 1;
        end else if (!hitNow) nCoin = 0;
        else begin
          nCoin = (mCoin == 7) ? 7 : mCoin + 1;
          if ((nCoin == 7 && eqOk) || noisy) begin nStd = 1; nCoin = 0; nMiss = 0; end
        end
      end
      if (eR || planForce) begin mHit = 0; mEq = 0; end
      else begin mHit = hitNow; mEq = (eqNow > 9) ? 9 : eqNow; end
      if (eR) mNoise = 0;
      else if (tk && fc == 100) mNoise = sy ? 1 : 0;
      else if (sy && inNoise(fc) && mNoise < 2) mNoise++;
      mStd = nStd; mCoin = nCoin; mMiss = nMiss;
      fcNext = tk ? (eR ? PRESET : fc + 1) : fc;
      if (eR) begin
        newField = 1;
        fieldIdx++;
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCH_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule